// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Shift Unit

This block is the combinational datapath core of a small processor. In a single pass it computes one of seven operations: add with carry, subtract with borrow, compare, and four one-bit shifts or rotates. It works on an eight-bit first operand, an eight-bit second operand and an incoming carry. It returns the result, the outgoing carry, the signed-overflow flag together with a qualifier that says whether that flag is meaningful, the negative and zero flags, and a write-enable. The write-enable tells the surrounding register file whether the result should be stored.

Arithmetic is binary only. Subtraction adds the inverted second operand and the carry, so a set carry means that no borrow occurred. Compare is a subtraction with the carry forced high, and it never asks for write-back. A shift or rotate sends the bit it pushes out into the carry. A rotate fills the vacated bit with the incoming carry, while a plain shift fills it with zero. A shift or rotate leaves overflow untouched, and the unit signals this by dropping the overflow qualifier.

Top module: `alu8_core`

## Requirements
- R1: Operation codes on `op_i` are fixed: 0 add, 1 subtract, 2 compare, 3 shift left, 4 shift right, 5 rotate left, 6 rotate right, and 7 reserved.
- R2: For code 0, `{c_o, res_o}` equals `a_i + b_i + c_i` taken as a nine-bit sum.
- R3: For code 1, `res_o` equals `a_i - b_i - (1 - c_i)` modulo 256, and `c_o` is 1 exactly when `a_i >= b_i + (1 - c_i)`, meaning no borrow occurs.
- R4: For codes 0, 1 and 2, `v_valid_o` is 1 and `v_o` is 1 exactly when the true signed result of the operation lies outside -128..127.
- R5: For code 2, the result and flags match code 1 with the incoming carry taken as 1 whatever `c_i` is, so `c_o` is 1 exactly when `a_i >= b_i`, and `wr_en_o` is 0.
- R6: For codes 3 and 5, `res_o` is `{a_i[6:0], fill}` and `c_o` is `a_i[7]`, where fill is 0 for code 3 and `c_i` for code 5. `b_i` has no effect.
- R7: For codes 4 and 6, `res_o` is `{fill, a_i[7:1]}` and `c_o` is `a_i[0]`, where fill is 0 for code 4 and `c_i` for code 6. `b_i` has no effect.
- R8: For codes 3 to 7, `v_valid_o` is 0 and `v_o` is 0.
- R9: For every code, `n_o` equals `res_o[7]` and `z_o` is 1 exactly when `res_o` is zero.
- R10: `wr_en_o` is 1 for codes 0, 1, 3, 4, 5 and 6.
- R11: Code 7 passes `a_i` to `res_o` and `c_i` to `c_o`, with `wr_en_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code |
| a_i | input | 8 | First operand, the value that is shifted |
| b_i | input | 8 | Second operand for add, subtract and compare |
| c_i | input | 1 | Incoming carry |
| res_o | output | 8 | Result |
| c_o | output | 1 | Outgoing carry |
| v_o | output | 1 | Signed overflow |
| v_valid_o | output | 1 | High when v_o should update the overflow flag |
| n_o | output | 1 | Negative flag of the result |
| z_o | output | 1 | Zero flag of the result |
| wr_en_o | output | 1 | High when the result should be stored |

## Verification
The hardest cases to reach are the edges of the carry and overflow logic. These are a subtraction whose borrow comes only from a clear incoming carry when the operands are equal, and a compare whose carry must ignore a clear `c_i`. Overflow also flips exactly at the boundary between 127 and 128. The stimulus therefore sweeps every operand pair with both carry values for add, subtract and compare, and it checks each against a signed-integer model. Every operand is also run through the four shifts and the reserved code with two unrelated second operands, which shows that `b_i` is ignored.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_CMP = 3'd2,
    OP_SHL = 3'd3,
    OP_SHR = 3'd4,
    OP_ROL = 3'd5,
    OP_ROR = 3'd6,
    OP_RSV = 3'd7
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         invert_b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] b_eff;
  logic [W:0]   total;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
    sum   = total[W-1:0];
    cout  = total[W];
    ovf   = (a[W-1] == b_eff[W-1]) && (total[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         to_left,
  input  logic         rotate,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  logic fill;

  always_comb begin
    fill = rotate & cin;
    if (to_left) begin
      res  = {a[W-2:0], fill};
      cout = a[W-1];
    end else begin
      res  = {fill, a[W-1:1]};
      cout = a[0];
    end
  end
endmodule

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output logic         neg,
  output logic         zero
);
  logic [W:0] any_set;

  assign any_set[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_or
    assign any_set[i+1] = any_set[i] | res[i];
  end

  assign neg  = res[W-1];
  assign zero = ~any_set[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
  parameter int W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o,
  output logic         v_valid_o,
  output logic         n_o,
  output logic         z_o,
  output logic         wr_en_o
);
  import alu8_pkg::*;

  alu_op_e      op;
  logic         is_arith, is_shift, do_sub, arith_cin;
  logic         sh_left, sh_rot;
  logic [W-1:0] arith_res, shift_res, res_mux;
  logic         arith_c, arith_v, shift_c;

  always_comb begin
    op        = alu_op_e'(op_i);
    is_arith  = (op == OP_ADD) || (op == OP_SUB) || (op == OP_CMP);
    is_shift  = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROL) || (op == OP_ROR);
    do_sub    = (op == OP_SUB) || (op == OP_CMP);
    arith_cin = (op == OP_CMP) ? 1'b1 : c_i;
    sh_left   = (op == OP_SHL) || (op == OP_ROL);
    sh_rot    = (op == OP_ROL) || (op == OP_ROR);
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a        (a_i),
    .b        (b_i),
    .invert_b (do_sub),
    .cin      (arith_cin),
    .sum      (arith_res),
    .cout     (arith_c),
    .ovf      (arith_v)
  );

  alu8_shift #(.W(W)) u_shift (
    .a       (a_i),
    .to_left (sh_left),
    .rotate  (sh_rot),
    .cin     (c_i),
    .res     (shift_res),
    .cout    (shift_c)
  );

  always_comb begin
    if (is_arith) begin
      res_mux = arith_res;
      c_o     = arith_c;
    end else if (is_shift) begin
      res_mux = shift_res;
      c_o     = shift_c;
    end else begin
      res_mux = a_i;
      c_o     = c_i;
    end
    v_valid_o = is_arith;
    v_o       = is_arith & arith_v;
    wr_en_o   = (op != OP_CMP) && (op != OP_RSV);
  end

  assign res_o = res_mux;

  alu8_flags #(.W(W)) u_flags (
    .res  (res_mux),
    .neg  (n_o),
    .zero (z_o)
  );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
  parameter int W = 8
) (
  input logic [2:0]   op_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b_i,
  input logic         c_i,
  input logic [W-1:0] res_o,
  input logic         c_o,
  input logic         v_o,
  input logic         v_valid_o,
  input logic         n_o,
  input logic         z_o,
  input logic         wr_en_o
);
  logic [W:0] add_ref;
  always_comb begin
    add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i};
    if (op_i == 3'd0) begin
      p_add_sum_r2: assert ({c_o, res_o} == add_ref)
        else $error("R2 add sum mismatch");
    end
    if (op_i == 3'd2) begin
      p_cmp_nowrite_r5: assert (!wr_en_o && (c_o == (a_i >= b_i)))
        else $error("R5 compare carry or write-enable wrong");
    end
    if (op_i == 3'd3 || op_i == 3'd5) begin
      p_left_carry_r6: assert (c_o == a_i[W-1] && res_o[W-1:1] == a_i[W-2:0])
        else $error("R6 left shift wrong");
    end
    if (op_i == 3'd4 || op_i == 3'd6) begin
      p_right_carry_r7: assert (c_o == a_i[0] && res_o[W-2:0] == a_i[W-1:1])
        else $error("R7 right shift wrong");
    end
    if (op_i >= 3'd3) begin
      p_no_overflow_r8: assert (!v_valid_o && !v_o)
        else $error("R8 overflow asserted on non-arithmetic code");
    end
    p_zero_flag_r9: assert (z_o == (res_o == '0) && n_o == res_o[W-1])
      else $error("R9 flag mismatch");
    if (op_i == 3'd7) begin
      p_reserved_r11: assert (res_o == a_i && c_o == c_i && !wr_en_o)
        else $error("R11 reserved code not a pass-through");
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (.*);

// File: tb/alu8_core_test.sv
`timescale 1ns/100ps
module alu8_core_test;
  logic       clk;
  logic [2:0] op_i;
  logic [7:0] a_i, b_i;
  logic       c_i;
  logic [7:0] res_o;
  logic       c_o, v_o, v_valid_o, n_o, z_o, wr_en_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  alu8_core #(.W(8)) uut (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .c_i(c_i),
    .res_o(res_o), .c_o(c_o), .v_o(v_o), .v_valid_o(v_valid_o),
    .n_o(n_o), .z_o(z_o), .wr_en_o(wr_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h (op=%0d a=%0h b=%0h c=%0b)",
             req, what, act, exp, op_i, a_i, b_i, c_i);
  endtask

  // Applies one vector and compares every output to a model built from R1..R11.
  task automatic run_vec(input int op, input int a, input int b, input int c);
    int eres, ec, ev, evv, ewe, sr, cin_eff;
    string req;
    op_i = 3'(op); a_i = 8'(a); b_i = 8'(b); c_i = 1'(c);
    #1;
    evv = 0; ev = 0; ewe = 1;
    case (op)
      0: begin
        req = "R2";
        eres = (a + b + c) % 256; ec = ((a + b + c) > 255) ? 1 : 0;
        sr = int'($signed(8'(a))) + int'($signed(8'(b))) + c;
        evv = 1; ev = (sr > 127 || sr < -128) ? 1 : 0;
      end
      1, 2: begin
        req = (op == 1) ? "R3" : "R5";
        cin_eff = (op == 2) ? 1 : c;
        eres = (a - b - (1 - cin_eff) + 512) % 256;
        ec = (a >= b + (1 - cin_eff)) ? 1 : 0;
        sr = int'($signed(8'(a))) - int'($signed(8'(b))) - (1 - cin_eff);
        evv = 1; ev = (sr > 127 || sr < -128) ? 1 : 0;
        ewe = (op == 2) ? 0 : 1;
      end
      3, 5: begin
        req = "R6";
        eres = ((a * 2) % 256) + ((op == 5) ? c : 0); ec = a / 128;
      end
      4, 6: begin
        req = "R7";
        eres = (a / 2) + ((op == 6) ? c * 128 : 0); ec = a % 2;
      end
      default: begin
        req = "R11"; eres = a; ec = c; ewe = 0;
      end
    endcase
    checks++;
    if (int'(res_o) != eres) fail_line(req, "res", int'(res_o), eres);
    else if (int'(c_o) != ec) fail_line(req, "carry", int'(c_o), ec);
    else if (int'(v_valid_o) != evv) fail_line((op < 3) ? "R4" : "R8", "v_valid", int'(v_valid_o), evv);
    else if (int'(v_o) != ev) fail_line((op < 3) ? "R4" : "R8", "v", int'(v_o), ev);
    else if (int'(n_o) != eres / 128) fail_line("R9", "n", int'(n_o), eres / 128);
    else if (int'(z_o) != ((eres == 0) ? 1 : 0)) fail_line("R9", "z", int'(z_o), (eres == 0) ? 1 : 0);
    else if (int'(wr_en_o) != ewe) fail_line((op == 2) ? "R5" : "R10", "wr_en", int'(wr_en_o), ewe);
    #1;
  endtask

  // R1 R2 R4: every pair, both carries, add
  task automatic t_add_all();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) run_vec(0, a, b, c);
  endtask

  // R3 R4: subtract sweep, including equal operands with borrow in
  task automatic t_sub_all();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) run_vec(1, a, b, c);
  endtask

  // R5: compare ignores c_i and never writes
  task automatic t_cmp_all();
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        for (int c = 0; c < 2; c++) run_vec(2, a, b, c);
  endtask

  // R6 R7 R8 R10 R11: b_i varied to show it is ignored
  task automatic t_shift_rsv_all();
    for (int op = 3; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) begin
          run_vec(op, a, 8'h00, c);
          run_vec(op, a, 8'hA5 ^ a, c);
        end
  endtask

  // R4 R9 corners: 123+45 overflows, 0x80-1 overflows, 0+0 zero
  task automatic t_corners();
    run_vec(0, 123, 45, 0);
    checks++;
    if (v_o !== 1'b1) fail_line("R4", "123+45 v", int'(v_o), 1);
    run_vec(1, 8'h80, 1, 1);
    run_vec(0, 0, 0, 0);
    checks++;
    if (z_o !== 1'b1) fail_line("R9", "zero z", int'(z_o), 1);
    run_vec(2, 5, 5, 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op_i = 3'd0; a_i = 8'd0; b_i = 8'd0; c_i = 1'b0;
    #5;
    t_corners();
    t_add_all();
    t_sub_all();
    t_cmp_all();
    t_shift_rsv_all();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule